// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the processor-side master for a 32-bit bus that carries the address and the data on the same lines, one after the other. A core-side request carries an address, four byte enables, a direction, a burst flag, a cache flag and an instruction/data flag. The block accepts a request only while it is idle. It then opens the transfer with a one-cycle address phase, marked by the ALE strobe. In that phase the upper 28 bus lines carry address bits 31:4 and the low four lines carry the byte enables. One or more data words follow.

Writes always move a single word, and the master drives the store data onto the bus. A read moves either one word or a burst of exactly four words. During read data the master releases the bus and captures each word when the responder raises `bus_rdy`. Each captured word goes back to the core with a one-cycle valid strobe. A separate 2-bit word-address output and two diagnostic outputs change meaning between the address phase and the data phase.

Top module: `adbus_master`

## Requirements
- R1: A request is taken only when `req_valid` is high while `req_ready` is high, and `req_ready` is high exactly when the block is idle. `busy` rises on the cycle after acceptance and stays high until the cycle after the last word's `bus_rdy` is sampled. A request presented while `busy` is high is ignored.
- R2: `ale` is high for exactly one cycle per transfer, in the first cycle after acceptance, and is low at all other times.
- R3: While `ale` is high, `ad[31:4]` equals the request address bits 31:4 and `ad[3:0]` equals the request byte enables.
- R4: In the data phase of a write, `ad` carries the write data and holds it until `bus_rdy` is sampled high.
- R5: In read data phases the master leaves `ad` undriven. Each word present on `ad` when `bus_rdy` is sampled high appears on `rd_data`, with `rd_valid` high for one cycle, in the following cycle.
- R6: A read with `req_burst` high transfers exactly four words. A read with `req_burst` low transfers exactly one. A write transfers one word whatever `req_burst` is.
- R7: For writes and single reads, `addr_lo` equals request address bits 3:2 through the whole transfer. For a burst read, `addr_lo` is 00 in the address phase and in the first word, increases by one after each sampled `bus_rdy`, and holds while `bus_rdy` is low.
- R8: For a read, `diag[1]` equals `req_miss` in the address phase and equals request address bit 3 in every data cycle.
- R9: For a read, `diag[0]` in the address phase equals `req_instr` when `req_miss` is high and is 0 when `req_miss` is low. In every data cycle it equals request address bit 2.
- R10: For a write, `diag[1]` equals `req_miss` (the store was also kept in the data cache) in the address phase and is 0 in the data phase. `diag[0]` is 0 throughout the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Read of four words (ignored for writes) |
| req_addr | input | 32 | Byte address of the transfer |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_miss | input | 1 | Read: caused by a cache miss; write: data kept in cache |
| req_instr | input | 1 | Miss read is an instruction fetch |
| ad | inout | 32 | Shared address/data bus |
| ale | output | 1 | Address latch strobe |
| addr_lo | output | 2 | Word address / burst counter |
| diag | output | 2 | Phase-multiplexed diagnostic outputs |
| bus_rdy | input | 1 | Responder acknowledges the current word |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 32 | Returned read word |
| rd_valid | output | 1 | `rd_data` valid this cycle |

## Verification
The hardest case to reach is a request arriving in the middle of a burst, while the master is stalled on a word. Such a request must leave the word counter, the diagnostics and the transfer length untouched. To get there, the stimulus holds `bus_rdy` low for several cycles inside a burst, raises `req_valid` with different fields during the stall, and then lets the burst finish. It then checks that exactly four words came back with the right counter values and that the block went idle. Stalled writes are used the same way, to show that the write data and `addr_lo` hold until the acknowledge.

// File: rtl/adbus_master.sv
module adbus_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_burst,
  input  logic [31:0] req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  input  logic        req_miss,
  input  logic        req_instr,
  inout  wire  [31:0] ad,
  output logic        ale,
  output logic [1:0]  addr_lo,
  output logic [1:0]  diag,
  input  logic        bus_rdy,
  output logic        busy,
  output logic [31:0] rd_data,
  output logic        rd_valid
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t         st;
  logic        wr_q, burst_q, miss_q, instr_q;
  logic [31:2] addr_q;
  logic [3:0]  be_q;
  logic [31:0] wdata_q;
  logic [1:0]  cnt;
  logic        last, drive;

  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign ale       = (st == S_ADDR);
  assign last      = !burst_q || (cnt == 2'd3);
  assign drive     = (st == S_ADDR) || (st == S_DATA && wr_q);
  assign ad        = drive ? ((st == S_ADDR) ? {addr_q[31:4], be_q} : wdata_q) : 'z;
  assign addr_lo   = burst_q ? cnt : addr_q[3:2];

  always_comb begin
    diag = 2'b00;
    if (st == S_ADDR)
      diag = {miss_q, !wr_q && miss_q && instr_q};
    else if (st == S_DATA && !wr_q)
      diag = addr_q[3:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_q     <= 1'b0;
      burst_q  <= 1'b0;
      miss_q   <= 1'b0;
      instr_q  <= 1'b0;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      cnt      <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_ADDR;
          wr_q    <= req_write;
          burst_q <= req_burst && !req_write;
          miss_q  <= req_miss;
          instr_q <= req_instr;
          addr_q  <= req_addr[31:2];
          be_q    <= req_be;
          wdata_q <= req_wdata;
          cnt     <= '0;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: if (bus_rdy) begin
          if (!wr_q) begin
            rd_data  <= ad;
            rd_valid <= 1'b1;
          end
          if (last) st <= S_IDLE;
          else      cnt <= cnt + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adbus_master_chk.sv
module adbus_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       ale,
  input logic       busy,
  input logic       bus_rdy,
  input logic       rd_valid,
  input logic [1:0] addr_lo
);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2

  AST_ALE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> $past(req_valid && !busy)); // R1

  AST_BUSY_OPENS_WITH_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale); // R2

  AST_IDLE_NO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ale); // R2

  AST_RDVALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_rdy && busy)); // R5

  AST_WORD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale && !bus_rdy) |=> $stable(addr_lo)); // R7

endmodule

bind adbus_master adbus_master_chk u_chk (.*);

// File: tb/adbus_master_tb.sv
`timescale 1ns/1ps
module adbus_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic        req_miss = 1'b0, req_instr = 1'b0, bus_rdy = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, ale, busy, rd_valid;
  logic [1:0]  addr_lo, diag;
  logic [31:0] rd_data;
  wire  [31:0] ad;
  logic        tb_en = 1'b0;
  logic [31:0] tb_d = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expq[$];

  assign ad = tb_en ? tb_d : 'z;

  always #2.5 clk = ~clk;

  adbus_master u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) check(1'b0, "R5 unexpected rd_valid", rd_data, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(rd_data === e, "R5 rd_data", rd_data, e);
      end
    end
  end

  task automatic check_data(input bit w, input bit b, input logic [31:0] a,
                            input logic [31:0] wd, input int i);
    logic [1:0] el;
    logic [1:0] ed;
    el = (b && !w) ? i[1:0] : a[3:2];
    ed = w ? 2'b00 : a[3:2];
    check(ale === 1'b0, "R2 ale low in data", {31'b0, ale}, 32'h0);
    check(busy === 1'b1, "R1 busy in data", {31'b0, busy}, 32'h1);
    check(addr_lo === el, "R7 addr_lo data", {30'b0, addr_lo}, {30'b0, el});
    check(diag[1] === ed[1], "R8 R10 diag1 data", {31'b0, diag[1]}, {31'b0, ed[1]});
    check(diag[0] === ed[0], "R9 R10 diag0 data", {31'b0, diag[0]}, {31'b0, ed[0]});
    if (w) check(ad === wd, "R4 write data", ad, wd);
  endtask

  task automatic txn(input bit w, input bit b, input logic [31:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input bit m, input bit ins, input int wt, input bit poke);
    int n;
    logic [1:0] el;
    n = (b && !w) ? 4 : 1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 ready when idle", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; req_write = w; req_burst = b; req_addr = a;
    req_be = be; req_wdata = wd; req_miss = m; req_instr = ins;
    @(negedge clk);
    req_valid = 1'b0;
    el = (b && !w) ? 2'b00 : a[3:2];
    check(ale === 1'b1, "R2 ale in address phase", {31'b0, ale}, 32'h1);
    check(busy === 1'b1, "R1 busy after accept", {31'b0, busy}, 32'h1);
    check(ad === {a[31:4], be}, "R3 address phase bus", ad, {a[31:4], be});
    check(addr_lo === el, "R7 addr_lo address phase", {30'b0, addr_lo}, {30'b0, el});
    check(diag[1] === m, "R8 R10 diag1 address phase", {31'b0, diag[1]}, {31'b0, m});
    check(diag[0] === (!w && m && ins), "R9 R10 diag0 address phase",
          {31'b0, diag[0]}, {31'b0, (!w && m && ins)});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_rdy = 1'b0; tb_en = 1'b0;
      for (int k = 0; k < wt; k++) begin
        check_data(w, b, a, wd, i);
        if (poke) begin
          req_valid = 1'b1; req_write = !w; req_burst = 1'b0;
          req_addr = ~a; req_be = ~be; req_miss = !m; req_instr = !ins;
        end
        @(negedge clk);
        if (poke) check(req_ready === 1'b0, "R1 no accept while busy", {31'b0, req_ready}, 32'h0);
      end
      req_valid = 1'b0;
      check_data(w, b, a, wd, i);
      bus_rdy = 1'b1;
      if (!w) begin
        tb_en = 1'b1;
        tb_d = a ^ (32'h0101_0101 * (i + 3));
        expq.push_back(tb_d);
      end
    end
    @(negedge clk);
    bus_rdy = 1'b0; tb_en = 1'b0;
    check(busy === 1'b0, "R1 R6 idle after last word", {31'b0, busy}, 32'h0);
    check(ale === 1'b0, "R2 ale low when idle", {31'b0, ale}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 reset busy", {31'b0, busy}, 32'h0);
    check(ale === 1'b0, "R2 reset ale", {31'b0, ale}, 32'h0);
    check(rd_valid === 1'b0, "R5 reset rd_valid", {31'b0, rd_valid}, 32'h0);
    check(req_ready === 1'b1, "R1 reset ready", {31'b0, req_ready}, 32'h1);
    // single reads: miss instruction, miss data, uncached
    txn(1'b0, 1'b0, 32'h1234_5678, 4'hF, 32'h0, 1'b1, 1'b1, 0, 1'b0);
    txn(1'b0, 1'b0, 32'hA5A5_A5A4, 4'h3, 32'h0, 1'b1, 1'b0, 2, 1'b0);
    txn(1'b0, 1'b0, 32'h0F0F_0F0C, 4'h8, 32'h0, 1'b0, 1'b1, 1, 1'b0);
    // burst reads, one with stalls and requests arriving mid-burst
    txn(1'b0, 1'b1, 32'hCAFE_BAB8, 4'hF, 32'h0, 1'b1, 1'b1, 0, 1'b0);
    txn(1'b0, 1'b1, 32'h8000_0004, 4'hF, 32'h0, 1'b1, 1'b0, 3, 1'b1);
    // writes: kept in cache, not kept, burst flag ignored, stalled with pokes
    txn(1'b1, 1'b0, 32'hDEAD_BEE8, 4'h1, 32'h1122_3344, 1'b1, 1'b1, 0, 1'b0);
    txn(1'b1, 1'b1, 32'h7654_321C, 4'hC, 32'h5566_7788, 1'b0, 1'b0, 2, 1'b0);
    txn(1'b1, 1'b0, 32'h0000_0004, 4'h6, 32'h99AA_BBCC, 1'b1, 1'b0, 3, 1'b1);
    // back-to-back read after write
    txn(1'b0, 1'b0, 32'hFFFF_FFFC, 4'hF, 32'h0, 1'b0, 1'b0, 0, 1'b0);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R5 R6 all read words returned", expq.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule